// File: doc/BRIEF.md
# Dual-Channel Staged Converter Code Register File

This block holds the digital side of a two-channel, 16-bit converter that a host programs over a parallel bus. Each channel has two registers. A staging register is written and read back over the bus. A live register holds the code that feeds the converter. The host writes either staging register while the converter outputs stay unchanged. One rising edge on the load strobe then moves both staged words into the live registers together, so the two outputs change in the same cycle.

The bus control lines (chip select, read/write, channel select, load and clear) arrive with no relation to the system clock. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies. A write is taken on the rising edge of chip select, the end of the access. The data word, channel and direction used are the ones sampled while chip select was still low. A rising edge on the clear input forces all four registers to a reset code. A parameter picks that code: half scale (MSB set) or zero.

The bus is modelled as a data-in port, a data-out port and an output enable, which together stand for one tri-state pad group.

Top module: `dual_dac_regfile`

## Requirements
- R1: While the synchronous reset `rst` is high, and after it falls, both live codes and both staging registers hold the reset code, and `bus_oe` is 0. The reset code is 16'h8000 when `MIDSCALE`=1 and 16'h0000 when `MIDSCALE`=0.
- R2: An access with `bus_cs_n` low and `bus_rd_wr`=0 stores `bus_din` into the staging register of the channel picked by `chan_sel` (0 = channel A, 1 = channel B). The store takes effect on the rising edge of `bus_cs_n`.
- R3: While `bus_cs_n` is low and `bus_rd_wr`=1, `bus_oe` is 1 and `bus_dout` shows the staging register of the channel picked by `chan_sel`.
- R4: While `bus_cs_n` is high, `bus_oe` is 0 (bus released).
- R5: Writing a staging register leaves `code_a` and `code_b` unchanged.
- R6: A 0-to-1 transition of `load_stb` copies both staging registers into both live registers in the same clock cycle.
- R7: Loading is edge triggered. Holding `load_stb` high does not copy staging words written later.
- R8: A 0-to-1 transition of `clear_stb` sets both staging and both live registers to the reset code.
- R9: When the clear edge and the load edge are seen in the same cycle, the clear wins and the live codes take the reset code.
- R10: One write access changes at most one staging register. The register of the other channel keeps its value.
- R11: Each control input passes through two synchronizer flops plus one edge register. Its effect is visible at the outputs no later than the third rising clock edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_cs_n | input | 1 | Chip select, active low (asynchronous) |
| bus_rd_wr | input | 1 | 1 = read staging register, 0 = write |
| chan_sel | input | 1 | Channel select, 0 = A, 1 = B |
| load_stb | input | 1 | Rising edge moves both staged words to the live registers |
| clear_stb | input | 1 | Rising edge forces all registers to the reset code |
| bus_din | input | DATA_W (16) | Data bus, inbound half |
| bus_dout | output | DATA_W (16) | Data bus, outbound half |
| bus_oe | output | 1 | Drive enable for the outbound bus half |
| code_a | output | DATA_W (16) | Live code of channel A |
| code_b | output | DATA_W (16) | Live code of channel B |

## Verification
The hardest case to reach is a clear edge and a load edge landing in the same synchronized cycle, with live registers that already hold non-reset values. The bench first loads distinct codes into both channels. It then raises both strobes at the same falling clock edge, so they travel through identical synchronizer chains and meet in one cycle. A second case holds the load strobe high across later writes, to show that a steady level triggers no transfer.

// File: rtl/dac_rf_pkg.sv
package dac_rf_pkg;

  // Synchronized view of the single-bit bus controls
  typedef struct packed {
    logic cs_n;
    logic rd;
    logic load;
    logic clr;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, rd: 1'b0, load: 1'b0, clr: 1'b0};

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dac_rf_sync.sv
module dac_rf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= INIT;
          else     pipe[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= INIT;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/dac_rf_edge.sv
module dac_rf_edge
  import dac_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl_s,
  input  logic [SEL_W-1:0]  sel_s,
  input  logic [DATA_W-1:0] din_s,
  output logic              wr_strobe,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              ld_rise,
  output logic              clr_rise,
  output logic              rd_active
);

  ctl_t              ctl_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_IDLE;
      sel_q <= '0;
      din_q <= '0;
    end else begin
      ctl_q <= ctl_s;
      sel_q <= sel_s;
      din_q <= din_s;
    end
  end

  // End of access: chip select returns high; use the qualifiers held while it was low
  assign wr_strobe = ctl_s.cs_n & ~ctl_q.cs_n & ~ctl_q.rd;
  assign wr_sel    = sel_q;
  assign wr_data   = din_q;
  assign ld_rise   = ctl_s.load & ~ctl_q.load;
  assign clr_rise  = ctl_s.clr  & ~ctl_q.clr;
  assign rd_active = ~ctl_s.cs_n & ctl_s.rd;

endmodule

// File: rtl/dac_rf_input_bank.sv
module dac_rf_input_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 1,
  parameter logic [DATA_W-1:0] RST_CODE = '0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_strobe,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           clr_rise,
  input  logic                           rd_active,
  input  logic [SEL_W-1:0]               rd_sel,
  output logic [NUM_CH-1:0][DATA_W-1:0]  in_word,
  output logic [NUM_CH-1:0]              wr_en,
  output logic [DATA_W-1:0]              bus_dout,
  output logic                           bus_oe
);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      assign wr_en[c] = wr_strobe & (wr_sel == SEL_W'(c));

      always_ff @(posedge clk) begin
        if (rst || clr_rise) in_word[c] <= RST_CODE;
        else if (wr_en[c])   in_word[c] <= wr_data;
      end
    end
  endgenerate

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_sel == SEL_W'(i)) rd_word = in_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      bus_oe   <= rd_active;
      bus_dout <= rd_active ? rd_word : '0;
    end
  end

endmodule

// File: rtl/dac_rf_output_bank.sv
module dac_rf_output_bank #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 2,
  parameter logic [DATA_W-1:0] RST_CODE = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld_rise,
  input  logic                          clr_rise,
  input  logic [NUM_CH-1:0][DATA_W-1:0] in_word,
  output logic [NUM_CH-1:0][DATA_W-1:0] out_word
);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst || clr_rise) out_word[c] <= RST_CODE;  // clear outranks load
        else if (ld_rise)    out_word[c] <= in_word[c];
      end
    end
  endgenerate

endmodule

// File: rtl/dual_dac_regfile.sv
module dual_dac_regfile
  import dac_rf_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          MIDSCALE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_rd_wr,
  input  logic              chan_sel,
  input  logic              load_stb,
  input  logic              clear_stb,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b
);

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned SEL_W  = sel_width(NUM_CH);
  localparam int unsigned CTL_W  = $bits(ctl_t);
  localparam int unsigned DS_W   = SEL_W + DATA_W;
  localparam logic [DATA_W-1:0] RST_CODE =
    MIDSCALE ? (DATA_W'(1) << (DATA_W - 1)) : '0;

  ctl_t              ctl_raw, ctl_s;
  logic [CTL_W-1:0]  ctl_s_vec;
  logic [DS_W-1:0]   ds_s;
  logic [SEL_W-1:0]  sel_s;
  logic [DATA_W-1:0] din_s;

  assign ctl_raw = '{cs_n: bus_cs_n, rd: bus_rd_wr, load: load_stb, clr: clear_stb};

  dac_rf_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .INIT(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s_vec)
  );

  dac_rf_sync #(.W(DS_W), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_data (
    .clk(clk), .rst(rst), .d({SEL_W'(chan_sel), bus_din}), .q(ds_s)
  );

  assign ctl_s = ctl_t'(ctl_s_vec);
  assign sel_s = ds_s[DS_W-1:DATA_W];
  assign din_s = ds_s[DATA_W-1:0];

  logic              cs_n_s, rd_s;
  logic              wr_strobe, ld_rise, clr_rise, rd_active;
  logic [SEL_W-1:0]  wr_sel;
  logic [DATA_W-1:0] wr_data;

  assign cs_n_s = ctl_s.cs_n;
  assign rd_s   = ctl_s.rd;

  dac_rf_edge #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_edge (
    .clk(clk), .rst(rst), .ctl_s(ctl_s), .sel_s(sel_s), .din_s(din_s),
    .wr_strobe(wr_strobe), .wr_sel(wr_sel), .wr_data(wr_data),
    .ld_rise(ld_rise), .clr_rise(clr_rise), .rd_active(rd_active)
  );

  logic [NUM_CH-1:0][DATA_W-1:0] in_word, out_word;
  logic [NUM_CH-1:0]             wr_en;

  dac_rf_input_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W),
                      .RST_CODE(RST_CODE)) u_in (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_sel(wr_sel),
    .wr_data(wr_data), .clr_rise(clr_rise), .rd_active(rd_active),
    .rd_sel(sel_s), .in_word(in_word), .wr_en(wr_en),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  dac_rf_output_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH),
                       .RST_CODE(RST_CODE)) u_out (
    .clk(clk), .rst(rst), .ld_rise(ld_rise), .clr_rise(clr_rise),
    .in_word(in_word), .out_word(out_word)
  );

  assign code_a = out_word[0];
  assign code_b = out_word[1];

endmodule

// File: rtl/dual_dac_regfile_chk.sv
module dual_dac_regfile_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 2,
  parameter logic [DATA_W-1:0] RST_CODE = '0
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          ld_rise,
  input logic                          clr_rise,
  input logic [NUM_CH-1:0]             wr_en,
  input logic [NUM_CH-1:0][DATA_W-1:0] in_word,
  input logic [NUM_CH-1:0][DATA_W-1:0] out_word,
  input logic                          bus_oe,
  input logic                          cs_n_s,
  input logic                          rd_s
);

  // R10: a single access stages at most one channel
  assert_one_writer_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  // R4 / R3: the bus is only driven after a synchronized read access
  assert_bus_release_R4: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(!cs_n_s && rd_s));

  // R8: clear forces every live word to the reset code
  assert_clear_live_R8: assert property (@(posedge clk) disable iff (rst)
    clr_rise |=> (out_word[0] == RST_CODE && out_word[NUM_CH-1] == RST_CODE));

  // R9: clear and load together still give the reset code
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_rise && ld_rise) |=> (out_word[0] == RST_CODE));

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      // R5 / R7: live word moves only on a load or clear edge
      assert_live_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!ld_rise && !clr_rise) |=> $stable(out_word[c]));
      // R6: load edge copies the staged word
      assert_load_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (ld_rise && !clr_rise) |=> (out_word[c] == $past(in_word[c])));
      // R2: staged word moves only on its own write or a clear
      assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en[c] && !clr_rise) |=> $stable(in_word[c]));
    end
  endgenerate

endmodule

bind dual_dac_regfile dual_dac_regfile_chk #(
  .DATA_W(DATA_W), .NUM_CH(NUM_CH), .RST_CODE(RST_CODE)
) u_chk (
  .clk(clk), .rst(rst), .ld_rise(ld_rise), .clr_rise(clr_rise),
  .wr_en(wr_en), .in_word(in_word), .out_word(out_word),
  .bus_oe(bus_oe), .cs_n_s(cs_n_s), .rd_s(rd_s)
);

// File: tb/dual_dac_regfile_bench.sv
module dual_dac_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_wr = 1'b0, sel = 1'b0, ld = 1'b0, clr = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout, dout_z, ca, cb, za, zb;
  logic        oe, oe_z;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] exp_in [2];
  logic [15:0] exp_out[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_regfile #(.MIDSCALE(1'b1)) u_dual_dac_regfile (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rd_wr(rd_wr), .chan_sel(sel),
    .load_stb(ld), .clear_stb(clr), .bus_din(din), .bus_dout(dout),
    .bus_oe(oe), .code_a(ca), .code_b(cb)
  );

  dual_dac_regfile #(.MIDSCALE(1'b0)) u_dual_dac_regfile_zero (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_rd_wr(rd_wr), .chan_sel(sel),
    .load_stb(ld), .clear_stb(clr), .bus_din(din), .bus_dout(dout_z),
    .bus_oe(oe_z), .code_a(za), .code_b(zb)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [15:0] v);
    sel = ch; rd_wr = 1'b0; din = v; cs_n = 1'b0;
    tick(SETTLE);
    cs_n = 1'b1;
    tick(SETTLE);
    exp_in[ch] = v;
  endtask

  task automatic rd_chk(input logic ch, input string req);
    sel = ch; rd_wr = 1'b1; cs_n = 1'b0;
    tick(SETTLE);
    chk({req, " R3 oe"}, {15'd0, oe}, 16'd1);
    chk({req, " R3 data"}, dout, exp_in[ch]);
    cs_n = 1'b1;
    tick(SETTLE);
    chk({req, " R4 released"}, {15'd0, oe}, 16'd0);
    rd_wr = 1'b0;
  endtask

  task automatic live_chk(input string req);
    chk({req, " code_a"}, ca, exp_out[0]);
    chk({req, " code_b"}, cb, exp_out[1]);
  endtask

  initial begin
    tick(3);
    // R1: reset state
    chk("R1 code_a during reset", ca, 16'h8000);
    rst = 1'b0;
    tick(2);
    exp_in[0] = 16'h8000; exp_in[1] = 16'h8000;
    exp_out[0] = 16'h8000; exp_out[1] = 16'h8000;
    live_chk("R1 after reset");
    chk("R1 zero variant a", za, 16'h0000);
    chk("R1 zero variant b", zb, 16'h0000);
    chk("R1 oe idle", {15'd0, oe}, 16'd0);
    rd_chk(1'b0, "R1 staged A");
    rd_chk(1'b1, "R1 staged B");

    // R2 R5 R6 R10: sweep of write/load patterns
    for (int k = 0; k < 10; k++) begin
      logic [15:0] va, vb;
      va = 16'(k * 16'h1D37 + 16'h0F01);
      vb = ~va ^ 16'(k << 4);
      if (k == 8) begin va = 16'hFFFF; vb = 16'h0000; end
      if (k == 9) begin va = 16'h7FFF; vb = 16'h8001; end
      wr(1'b0, va);
      live_chk("R5 after write A");
      rd_chk(1'b1, "R10 B untouched by A write");
      wr(1'b1, vb);
      live_chk("R5 after write B");
      rd_chk(1'b0, "R2 readback A");
      rd_chk(1'b1, "R2 readback B");
      ld = 1'b1;
      // R11: load edge visible at third rising edge
      tick(2);
      live_chk("R11 not yet loaded");
      tick(1);
      exp_out[0] = exp_in[0]; exp_out[1] = exp_in[1];
      live_chk("R6 R11 both loaded together");
      ld = 1'b0;
      tick(SETTLE);
    end

    // R7: steady high load level does not transfer later writes
    ld = 1'b1;
    tick(SETTLE);
    wr(1'b0, 16'h1234);
    wr(1'b1, 16'hABCD);
    live_chk("R7 level held, no reload");
    ld = 1'b0;
    tick(SETTLE);
    live_chk("R7 falling edge, no reload");
    ld = 1'b1;
    tick(SETTLE);
    exp_out[0] = 16'h1234; exp_out[1] = 16'hABCD;
    live_chk("R7 next rising edge loads");
    ld = 1'b0;
    tick(SETTLE);

    // R8: clear edge resets staged and live words
    clr = 1'b1;
    tick(SETTLE);
    exp_in[0] = 16'h8000; exp_in[1] = 16'h8000;
    exp_out[0] = 16'h8000; exp_out[1] = 16'h8000;
    live_chk("R8 clear live");
    chk("R8 zero variant a", za, 16'h0000);
    chk("R8 zero variant b", zb, 16'h0000);
    clr = 1'b0;
    tick(SETTLE);
    rd_chk(1'b0, "R8 clear staged A");
    rd_chk(1'b1, "R8 clear staged B");

    // R9: clear and load in the same cycle
    wr(1'b0, 16'h5A5A);
    wr(1'b1, 16'hC3C3);
    ld = 1'b1; tick(SETTLE); ld = 1'b0; tick(SETTLE);
    exp_out[0] = 16'h5A5A; exp_out[1] = 16'hC3C3;
    live_chk("R9 preload");
    wr(1'b0, 16'h0001);
    ld = 1'b1; clr = 1'b1;
    tick(SETTLE);
    exp_in[0] = 16'h8000; exp_in[1] = 16'h8000;
    exp_out[0] = 16'h8000; exp_out[1] = 16'h8000;
    live_chk("R9 clear beats load");
    ld = 1'b0; clr = 1'b0;
    tick(SETTLE);
    rd_chk(1'b0, "R9 staged A cleared");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-side run hung actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule